// File: doc/BRIEF.md
# Multiphase Pulse Clock Generator

This block divides an input clock by two and by four, and forms four non-overlapping phase pulses plus one merged pulse from it. Each divide-by-two period is cut into four equal quarters, each half an input clock period long. Exactly one phase pulse is high in each quarter, and they rotate in a fixed order. The merged pulse spans the second and third quarters.

The phase pulses are not registered. A small decoder derives them from the level of the input clock together with the divide-by-two clock, gated by a registered run flag. A synchronous enable starts and stops the divider. While it is low, the divided clocks hold and the pulses stay low. A synchronous clear returns every output to zero. An asynchronous active-low reset, released through a two-flop synchronizer, sets the same state as clear.

Top module: `mphase_pulse_gen`

## Requirements
- R1: At each rising edge of `clk_in` with `en`=1 and `clr`=0 (an advancing edge), `div2_o` toggles, so it has twice the input clock period.
- R2: `div4_o` toggles at an advancing edge exactly when `div2_o` was high before that edge, so it has four times the input clock period.
- R3: At a rising edge with `en`=0 and `clr`=0, `div2_o` and `div4_o` keep their values, and `ph_o` and `ph_mid_o` stay 0 until the next advancing edge.
- R4: At a rising edge with `clr`=1, whatever `en` is, `div2_o`, `div4_o`, `ph_o` and `ph_mid_o` all become 0.
- R5: At most one bit of `ph_o` is high at any time.
- R6: After an advancing edge, `ph_o` bit i marks quarter i+1: bit 0 when `div2_o` and `clk_in` are both high, bit 1 when `div2_o` is high and `clk_in` is low, bit 2 when `div2_o` is low and `clk_in` is high, and bit 3 when both are low.
- R7: `ph_mid_o` is high exactly when `ph_o` bit 1 or bit 2 is high.
- R8: A change of `en` or `clr` between rising edges leaves every output unchanged until the next rising edge.
- R9: While `rst_n` is low, every output is 0, and release of reset passes through two `clk_in` flops before the divider can advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock; its level also feeds the phase decode |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, takes priority over enable |
| en | input | 1 | Synchronous run enable |
| div2_o | output | 1 | Input clock divided by two |
| div4_o | output | 1 | Input clock divided by four |
| ph_o | output | 4 | Phase pulses, bit i high in quarter i+1 |
| ph_mid_o | output | 1 | Pulse covering quarters two and three |

## Verification
The assertions assume that `en` and `clr` are stable around each rising edge of `clk_in` and change only while the clock is low. They also sample the phase outputs at both clock edges, where the combinational decode has settled on the level just before the edge. The bench drives every input change two time units after a falling edge and samples outputs two time units into each half period. It sweeps all 1024 five-cycle sequences of the four enable/clear combinations, so that hold, clear and advance follow each other from every divider state.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int PH_COUNT = 4;
  localparam int DIV_BITS = 2;
  localparam int Q_BITS   = $clog2(PH_COUNT);

  typedef enum logic [Q_BITS-1:0] {
    Q_FIRST  = 2'd0,
    Q_SECOND = 2'd1,
    Q_THIRD  = 2'd2,
    Q_FOURTH = 2'd3
  } quarter_e;

  // Quarter index: high half of div2 comes first, high clock level first.
  function automatic quarter_e quarter_of(input logic div2, input logic clk_lvl);
    return quarter_e'({~div2, ~clk_lvl});
  endfunction
endpackage

// File: rtl/mpg_rst_sync.sv
module mpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mpg_divider.sv
module mpg_divider #(
  parameter int DIV_BITS = mpg_pkg::DIV_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  output logic [DIV_BITS-1:0] div_o,
  output logic                run_o
);
  logic [DIV_BITS-1:0] cnt_q, cnt_d;
  logic                run_q, run_d;
  logic                adv;

  assign adv = en & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    run_d = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      run_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign div_o = cnt_q;
  assign run_o = run_q;

  a_r1_div2_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (cnt_q[0] != $past(cnt_q[0])));

  a_r2_div4_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cnt_q[0]) |=> (cnt_q[1] != $past(cnt_q[1])));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(cnt_q) && !run_q));

  a_r4_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !run_q));
endmodule

// File: rtl/mpg_phase_decode.sv
module mpg_phase_decode
  import mpg_pkg::*;
#(
  parameter int PH_COUNT = mpg_pkg::PH_COUNT
) (
  input  logic                clk_lvl,
  input  logic                rst_n,
  input  logic                div2,
  input  logic                run,
  output logic [PH_COUNT-1:0] ph_o,
  output logic                ph_mid_o
);
  quarter_e q;

  always_comb begin
    q = quarter_of(div2, clk_lvl);
  end

  for (genvar i = 0; i < PH_COUNT; i++) begin : g_phase
    assign ph_o[i] = run & (q == quarter_e'(i));
  end

  assign ph_mid_o = run & ((q == Q_SECOND) | (q == Q_THIRD));

  a_r5_onehot_rise: assert property (@(posedge clk_lvl) disable iff (!rst_n)
    $onehot0(ph_o));

  a_r5_onehot_fall: assert property (@(negedge clk_lvl) disable iff (!rst_n)
    $onehot0(ph_o));
endmodule

// File: rtl/mphase_pulse_gen.sv
module mphase_pulse_gen
  import mpg_pkg::*;
(
  input  logic                clk_in,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  output logic                div2_o,
  output logic                div4_o,
  output logic [PH_COUNT-1:0] ph_o,
  output logic                ph_mid_o
);
  localparam int RST_STAGES = 2;

  logic                rst_sync_n;
  logic [DIV_BITS-1:0] div_w;
  logic                run_w;

  mpg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mpg_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk   (clk_in),
    .rst_n (rst_sync_n),
    .clr   (clr),
    .en    (en),
    .div_o (div_w),
    .run_o (run_w)
  );

  mpg_phase_decode #(.PH_COUNT(PH_COUNT)) u_dec (
    .clk_lvl  (clk_in),
    .rst_n    (rst_sync_n),
    .div2     (div_w[0]),
    .run      (run_w),
    .ph_o     (ph_o),
    .ph_mid_o (ph_mid_o)
  );

  assign div2_o = div_w[0];
  assign div4_o = div_w[1];

  // Sampled at a falling edge the clock level is high; at a rising edge it is low.
  a_r6_first_quarter: assert property (@(negedge clk_in) disable iff (!rst_sync_n)
    (run_w && div2_o) |-> ph_o[0]);

  a_r6_third_quarter: assert property (@(negedge clk_in) disable iff (!rst_sync_n)
    (run_w && !div2_o) |-> ph_o[2]);

  a_r6_second_quarter: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    (run_w && div2_o) |-> ph_o[1]);

  a_r6_fourth_quarter: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    (run_w && !div2_o) |-> ph_o[3]);

  a_r4_pulses_cleared: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    clr |=> (ph_o == '0 && !ph_mid_o && !div2_o && !div4_o));
endmodule

// File: tb/mphase_pulse_gen_test.sv
module mphase_pulse_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic clk_in = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b1;
  logic en = 1'b0;
  logic div2_o, div4_o, ph_mid_o;
  logic [3:0] ph_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] e_cnt = 2'd0;
  logic       e_run = 1'b0;

  mphase_pulse_gen uut (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .clr      (clr),
    .en       (en),
    .div2_o   (div2_o),
    .div4_o   (div4_o),
    .ph_o     (ph_o),
    .ph_mid_o (ph_mid_o)
  );

  always #HALF clk_in = ~clk_in;

  task automatic cmp(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
    end
  endtask

  // Compare all outputs with the model; hi = clock level at sample time.
  task automatic check_all(input string rdiv, input string rph, input bit hi);
    int q;
    int exp_ph;
    q = (e_cnt[0] ? 0 : 2) + (hi ? 0 : 1);
    exp_ph = e_run ? (1 << q) : 0;
    cmp({rdiv, " div2"}, int'(div2_o), int'(e_cnt[0]));
    cmp("R2 div4", int'(div4_o), int'(e_cnt[1]));
    cmp(rph, int'(ph_o), exp_ph);
    cmp("R7 mid pulse", int'(ph_mid_o), (exp_ph & 6) != 0 ? 1 : 0);
    cmp("R5 onehot", ($countones(ph_o) <= 1) ? 1 : 0, 1);
  endtask

  // Called during the low half: drive, check no early effect, pass one edge.
  task automatic step(input bit e, input bit c);
    string rd, rp;
    en = e;
    clr = c;
    #1;
    check_all("R8 pre-edge", "R8 pulses pre-edge", 1'b0);
    @(posedge clk_in);
    if (c) begin
      e_cnt = 2'd0; e_run = 1'b0; rd = "R4"; rp = "R4 pulses after clr";
    end else if (e) begin
      e_cnt = e_cnt + 2'd1; e_run = 1'b1; rd = "R1"; rp = "R6 phase decode";
    end else begin
      e_run = 1'b0; rd = "R3"; rp = "R3 pulses idle";
    end
    #2;
    check_all(rd, rp, 1'b1);
    @(negedge clk_in);
    #2;
    check_all(rd, rp, 1'b0);
  endtask

  initial begin
    #(HALF + 2);
    // R9: outputs zero while reset is held
    cmp("R9 reset div2", int'(div2_o), 0);
    cmp("R9 reset div4", int'(div4_o), 0);
    cmp("R9 reset ph", int'(ph_o), 0);
    cmp("R9 reset mid", int'(ph_mid_o), 0);
    @(negedge clk_in);
    #2;
    rst_n = 1'b1;
    // R9: enable during synchronizer latency must not advance
    en = 1'b1;
    clr = 1'b0;
    @(posedge clk_in);
    #2;
    cmp("R9 sync stage 1", int'(div2_o), 0);
    @(negedge clk_in);
    #2;
    en = 1'b0;
    clr = 1'b1;
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
    for (int s = 0; s < 1024; s++) begin
      for (int k = 0; k < 5; k++) begin
        int code;
        code = (s >> (2 * k)) & 3;
        step(code[0], code[1]);
      end
    end
    // long advancing run: full rotation of quarters
    for (int k = 0; k < 16; k++) step(1'b1, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule